// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

This block is a small 16-bit processor that runs each instruction as a short sequence of clock cycles. A Moore-style controller walks through fetch, decode and one or more execute states. Instructions and data live in one shared word-addressed memory that sits outside the block. The core drives a single address bus with a read strobe and a write strobe. Read data must come back registered, one cycle after the address. The program counter is advanced through the same ALU that executes arithmetic.

The core has eight 16-bit general registers, all cleared by reset. It also holds an instruction register, a program counter and a memory address register. The top memory word acts as a display port: each store to it is also captured in an output register. A halt instruction parks the core until the next reset.

Instruction formats use op = bits [15:13], rs = [12:10] and rt = [9:7]. R-type adds rd = [6:4] and funct = [3:0]. I-type adds a signed 7-bit offset in [6:0]. J-type carries a 13-bit target in [12:0].

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the core is in fetch: `mem_rd`=1, `mem_addr`=0 and `mem_wr`=0. `halted` and `disp_out` are 0, and all eight registers read as 0 afterwards.
- R2: Every fetch cycle reads memory at the PC and increments the PC by one through the ALU. The next cycle is decode.
- R3: Opcode 0 writes `rd` from `rs` and `rt` according to funct: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). It takes 3 cycles.
- R4: Opcode 4 writes `rt` = `rs` + sign-extended offset in 3 cycles.
- R5: Opcode 1 loads `rt` from memory at the low address bits of `rs` + sign-extended offset. It takes 5 cycles.
- R6: Opcode 2 stores `rt` to memory at the low address bits of `rs` + sign-extended offset. It takes 4 cycles.
- R7: Opcode 3, when `rs` equals `rt`, sets PC = (incremented PC) + sign-extended offset; otherwise execution continues in sequence. Either way it takes 3 cycles.
- R8: Opcode 5 loads the PC with the zero-extended 13-bit target in 3 cycles.
- R9: Opcode 7 raises `halted` two cycles after its fetch. After that, `halted` stays high and the core makes no memory access until reset.
- R10: Opcode 6, and opcode 0 with a funct above 4, change no register and no memory. They take 2 cycles and then the next instruction is fetched.
- R11: A store to the highest address (255 by default) loads `disp_out` with the stored data. A store to any other address leaves `disp_out` unchanged.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address to the shared memory |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Registered read data from memory |
| disp_out | output | 16 | Last value stored to the display word |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench aims at the places where a multicycle sequencer most often slips. A branch offset added to the un-incremented PC would land one word early, and a backward loop would then never exit. An offset that is zero-extended would send a negative store to the wrong word. An undefined funct that falls into the register write path would clobber `rd`. The display register is also checked to ignore the neighbouring address, so an off-by-one in the address compare shows up. Each program's cycle count up to `halted` is also measured, so a missing or extra execute state in the load, store or no-op paths changes the count and is reported.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int XLEN   = 16;
  localparam int REG_AW = 3;
  localparam int NREG   = 1 << REG_AW;
  localparam int IMM_W  = 7;
  localparam int TGT_W  = 13;

  localparam logic [2:0] OP_REG   = 3'd0;
  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_STORE = 3'd2;
  localparam logic [2:0] OP_BEQ   = 3'd3;
  localparam logic [2:0] OP_ADDI  = 3'd4;
  localparam logic [2:0] OP_JMP   = 3'd5;
  localparam logic [2:0] OP_HALT  = 3'd7;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG, SRCB_ONE, SRCB_IMM
  } srcb_e;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXALU, S_EXADDI, S_EXBEQ, S_EXJMP,
    S_MADDR, S_MREAD, S_MWB, S_MWRITE, S_HALT
  } state_e;

  typedef struct packed {
    logic    mem_rd;
    logic    mem_wr;
    logic    addr_mar;
    logic    alu_a_pc;
    srcb_e   srcb;
    alu_op_e alu_op;
    logic    pc_ld;
    logic    pc_branch;
    logic    pc_jmp;
    logic    ir_ld;
    logic    rf_rd_en;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mem;
    logic    mar_ld;
  } ctrl_t;

endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = ($signed(a_i) < $signed(b_i)) ? W'(1) : W'(0);
      default: y_o = a_i + b_i;
    endcase
  end

endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile
  import mc16_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NR = NREG,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_i,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  q_a_o,
  output logic [W-1:0]  q_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);

  logic [W-1:0] regs_q [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_a_o <= '0;
      q_b_o <= '0;
    end else if (rd_en_i) begin
      q_a_o <= regs_q[ra_a_i];
      q_b_o <= regs_q[ra_b_i];
    end
  end

  AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> ($stable(q_a_o) && $stable(q_b_o))) else $error("operands moved"); // R3

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] dec_op_i,
  input  logic [3:0] dec_funct_i,
  input  logic [2:0] ir_op_i,
  input  logic [3:0] ir_funct_i,
  output state_e     state_o,
  output ctrl_t      ctl_o
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        unique case (dec_op_i)
          OP_REG:   state_d = (dec_funct_i <= 4'd4) ? S_EXALU : S_FETCH;
          OP_LOAD,
          OP_STORE: state_d = S_MADDR;
          OP_BEQ:   state_d = S_EXBEQ;
          OP_ADDI:  state_d = S_EXADDI;
          OP_JMP:   state_d = S_EXJMP;
          OP_HALT:  state_d = S_HALT;
          default:  state_d = S_FETCH;
        endcase
      end
      S_MADDR:  state_d = (ir_op_i == OP_LOAD) ? S_MREAD : S_MWRITE;
      S_MREAD:  state_d = S_MWB;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    ctl_o = '0;
    unique case (state_q)
      S_FETCH: begin
        ctl_o.mem_rd   = 1'b1;
        ctl_o.alu_a_pc = 1'b1;
        ctl_o.srcb     = SRCB_ONE;
        ctl_o.alu_op   = ALU_ADD;
        ctl_o.pc_ld    = 1'b1;
      end
      S_DECODE: begin
        ctl_o.ir_ld    = 1'b1;
        ctl_o.rf_rd_en = 1'b1;
      end
      S_EXALU: begin
        ctl_o.srcb      = SRCB_REG;
        ctl_o.rf_we     = 1'b1;
        ctl_o.rf_dst_rd = 1'b1;
        unique case (ir_funct_i)
          4'd1:    ctl_o.alu_op = ALU_SUB;
          4'd2:    ctl_o.alu_op = ALU_AND;
          4'd3:    ctl_o.alu_op = ALU_OR;
          4'd4:    ctl_o.alu_op = ALU_SLT;
          default: ctl_o.alu_op = ALU_ADD;
        endcase
      end
      S_EXADDI: begin
        ctl_o.srcb  = SRCB_IMM;
        ctl_o.rf_we = 1'b1;
      end
      S_EXBEQ: begin
        ctl_o.alu_a_pc  = 1'b1;
        ctl_o.srcb      = SRCB_IMM;
        ctl_o.pc_branch = 1'b1;
      end
      S_EXJMP:  ctl_o.pc_jmp = 1'b1;
      S_MADDR: begin
        ctl_o.srcb   = SRCB_IMM;
        ctl_o.mar_ld = 1'b1;
      end
      S_MREAD: begin
        ctl_o.mem_rd   = 1'b1;
        ctl_o.addr_mar = 1'b1;
      end
      S_MWB: begin
        ctl_o.rf_we       = 1'b1;
        ctl_o.rf_from_mem = 1'b1;
      end
      S_MWRITE: begin
        ctl_o.mem_wr   = 1'b1;
        ctl_o.addr_mar = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_FETCH) |=> (state_q == S_DECODE)) else $error("fetch not followed by decode"); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HALT) |=> (state_q == S_HALT)) else $error("left halt"); // R9
  AST_LOAD_WB: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MREAD) |=> ctl_o.rf_from_mem) else $error("load skipped write-back"); // R5

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   disp_out,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] DISP_ADDR = {ADDR_W{1'b1}};

  ctrl_t            ctl;
  state_e           state;
  logic [XLEN-1:0]  pc_q, ir_q;
  logic [ADDR_W-1:0] mar_q;
  logic [XLEN-1:0]  opa, opb, alu_a, alu_b, alu_y, imm_sx, rf_wd;
  logic [REG_AW-1:0] rf_wa;

  mc16_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .dec_op_i    (mem_rdata[15:13]),
    .dec_funct_i (mem_rdata[3:0]),
    .ir_op_i     (ir_q[15:13]),
    .ir_funct_i  (ir_q[3:0]),
    .state_o     (state),
    .ctl_o       (ctl)
  );

  assign rf_wa = ctl.rf_dst_rd ? ir_q[6:4] : ir_q[9:7];
  assign rf_wd = ctl.rf_from_mem ? mem_rdata : alu_y;

  mc16_regfile #(.W(XLEN), .NR(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (ctl.rf_rd_en),
    .ra_a_i  (mem_rdata[12:10]),
    .ra_b_i  (mem_rdata[9:7]),
    .q_a_o   (opa),
    .q_b_o   (opb),
    .we_i    (ctl.rf_we),
    .wa_i    (rf_wa),
    .wd_i    (rf_wd)
  );

  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign alu_a  = ctl.alu_a_pc ? pc_q : opa;

  always_comb begin
    unique case (ctl.srcb)
      SRCB_ONE: alu_b = XLEN'(1);
      SRCB_IMM: alu_b = imm_sx;
      default:  alu_b = opb;
    endcase
  end

  mc16_alu #(.W(XLEN)) u_alu (
    .a_i  (alu_a),
    .b_i  (alu_b),
    .op_i (ctl.alu_op),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (ctl.pc_ld) begin
      pc_q <= alu_y;
    end else if (ctl.pc_branch && (opa == opb)) begin
      pc_q <= alu_y;
    end else if (ctl.pc_jmp) begin
      pc_q <= {{(XLEN-TGT_W){1'b0}}, ir_q[TGT_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= '0;
      mar_q <= '0;
    end else begin
      if (ctl.ir_ld)  ir_q  <= mem_rdata;
      if (ctl.mar_ld) mar_q <= alu_y[ADDR_W-1:0];
    end
  end

  assign mem_addr  = ctl.addr_mar ? mar_q : pc_q[ADDR_W-1:0];
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = opb;
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) disp_out <= '0;
    else if (mem_wr && (mem_addr == DISP_ADDR)) disp_out <= mem_wdata;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)) else $error("read and write together"); // R12
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr)) else $error("access while halted"); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(1))) else $error("pc not stepped"); // R2
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && (mem_addr == DISP_ADDR)) |=> $stable(disp_out)) else $error("display moved"); // R11

endmodule

// File: tb/tb_mc16_core.sv
`timescale 1ns/1ps
module tb_mc16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata, disp_out;
  logic        halted;
  logic [15:0] mem [0:255];
  int checks = 0, errors = 0, overlap = 0;

  always #2 clk = ~clk;

  mc16_core #(.ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .disp_out(disp_out), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) if (!rst && mem_rd && mem_wr) overlap++;

  function automatic logic [15:0] enc_r(logic [2:0] rs, logic [2:0] rt, logic [2:0] rd, logic [3:0] fn);
    return {3'd0, rs, rt, rd, fn};
  endfunction
  function automatic logic [15:0] enc_i(logic [2:0] op, logic [2:0] rs, logic [2:0] rt, logic [6:0] off);
    return {op, rs, rt, off};
  endfunction
  function automatic logic [15:0] enc_j(logic [12:0] tgt);
    return {3'd5, tgt};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hE000;
  endtask

  task automatic run_prog(output int cyc);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_alu();
    int c;
    clear_mem();
    mem[0]  = enc_i(3'd4, 3'd0, 3'd1, 7'd7);
    mem[1]  = enc_i(3'd4, 3'd0, 3'd2, 7'h7D);
    mem[2]  = enc_r(3'd1, 3'd2, 3'd3, 4'd0);
    mem[3]  = enc_r(3'd1, 3'd2, 3'd4, 4'd1);
    mem[4]  = enc_r(3'd1, 3'd2, 3'd5, 4'd2);
    mem[5]  = enc_r(3'd1, 3'd2, 3'd6, 4'd3);
    mem[6]  = enc_r(3'd2, 3'd1, 3'd7, 4'd4);
    for (int i = 0; i < 5; i++) mem[7+i] = enc_i(3'd2, 3'd0, 3'(3+i), 7'(40+i));
    mem[12] = enc_r(3'd1, 3'd2, 3'd3, 4'd4);
    mem[13] = enc_i(3'd2, 3'd0, 3'd3, 7'd45);
    run_prog(c);
    chk("R3", "add", 32'(mem[40]), 32'h0004);
    chk("R3", "sub", 32'(mem[41]), 32'h000A);
    chk("R3", "and", 32'(mem[42]), 32'h0005);
    chk("R3", "or",  32'(mem[43]), 32'hFFFF);
    chk("R3", "slt true", 32'(mem[44]), 32'h0001);
    chk("R3", "slt false", 32'(mem[45]), 32'h0000);
    chk("R4", "cycles addi/R/sw", 32'(c), 32'd50);
  endtask

  task automatic t_disp();
    int c;
    clear_mem();
    mem[0] = enc_i(3'd4, 3'd0, 3'd1, 7'd42);
    mem[1] = enc_i(3'd4, 3'd0, 3'd2, 7'h7E);
    mem[2] = enc_i(3'd2, 3'd2, 3'd1, 7'd0);
    run_prog(c);
    chk("R11", "store to 254 keeps display", 32'(disp_out), 32'h0);
    chk("R6", "store to 254 data", 32'(mem[254]), 32'd42);
    mem[1] = enc_i(3'd4, 3'd0, 3'd2, 7'h7F);
    mem[254] = 16'hE000;
    run_prog(c);
    chk("R11", "store to 255 sets display", 32'(disp_out), 32'd42);
  endtask

  task automatic t_reset();
    int c;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "display cleared", 32'(disp_out), 32'h0);
    chk("R1", "halted low", 32'(halted), 32'h0);
    chk("R1", "fetch at 0", {mem_rd, mem_wr, 22'h0, mem_addr}, {1'b1, 1'b0, 30'h0});
    clear_mem();
    mem[0] = enc_i(3'd2, 3'd0, 3'd7, 7'd40);
    run_prog(c);
    chk("R1", "register cleared", 32'(mem[40]), 32'h0);
  endtask

  task automatic t_ldst();
    int c;
    clear_mem();
    mem[60] = 16'h1234;
    mem[0] = enc_i(3'd4, 3'd0, 3'd1, 7'd50);
    mem[1] = enc_i(3'd1, 3'd1, 3'd2, 7'd10);
    mem[2] = enc_i(3'd2, 3'd1, 3'd2, 7'h7B);
    run_prog(c);
    chk("R5", "load then store negative offset", 32'(mem[45]), 32'h1234);
    chk("R6", "cycles addi+lw+sw", 32'(c), 32'd14);
  endtask

  task automatic t_branch();
    int c;
    clear_mem();
    mem[0] = enc_i(3'd4, 3'd0, 3'd1, 7'd3);
    mem[1] = enc_i(3'd4, 3'd0, 3'd2, 7'd3);
    mem[2] = enc_i(3'd3, 3'd1, 3'd2, 7'd2);
    mem[3] = enc_i(3'd4, 3'd0, 3'd3, 7'd1);
    mem[4] = enc_i(3'd4, 3'd0, 3'd3, 7'd2);
    mem[5] = enc_i(3'd4, 3'd0, 3'd4, 7'd9);
    mem[6] = enc_i(3'd3, 3'd1, 3'd0, 7'd1);
    mem[7] = enc_i(3'd4, 3'd0, 3'd5, 7'd6);
    mem[8] = enc_i(3'd2, 3'd0, 3'd3, 7'd40);
    mem[9] = enc_i(3'd2, 3'd0, 3'd4, 7'd41);
    mem[10] = enc_i(3'd2, 3'd0, 3'd5, 7'd42);
    run_prog(c);
    chk("R7", "taken skips", 32'(mem[40]), 32'h0);
    chk("R7", "target executed", 32'(mem[41]), 32'd9);
    chk("R7", "not taken falls through", 32'(mem[42]), 32'd6);
    chk("R7", "cycles", 32'(c), 32'd32);
  endtask

  task automatic t_jump();
    int c;
    clear_mem();
    mem[0] = enc_j(13'd4);
    for (int i = 1; i < 4; i++) mem[i] = enc_i(3'd4, 3'd0, 3'd1, 7'd1);
    mem[4]  = enc_i(3'd4, 3'd0, 3'd2, 7'd2);
    mem[5]  = enc_i(3'd4, 3'd0, 3'd3, 7'd3);
    mem[6]  = enc_i(3'd4, 3'd3, 3'd3, 7'h7F);
    mem[7]  = enc_i(3'd3, 3'd3, 3'd0, 7'd1);
    mem[8]  = enc_i(3'd3, 3'd0, 3'd0, 7'h7D);
    mem[9]  = enc_i(3'd2, 3'd0, 3'd1, 7'd40);
    mem[10] = enc_i(3'd2, 3'd0, 3'd2, 7'd41);
    mem[11] = enc_i(3'd2, 3'd0, 3'd3, 7'd42);
    run_prog(c);
    chk("R8", "jump skipped words", 32'(mem[40]), 32'h0);
    chk("R8", "jump target ran", 32'(mem[41]), 32'd2);
    chk("R7", "backward loop exit", 32'(mem[42]), 32'h0);
  endtask

  task automatic t_undef();
    int c;
    clear_mem();
    mem[0] = enc_i(3'd4, 3'd0, 3'd1, 7'd5);
    mem[1] = enc_i(3'd6, 3'd0, 3'd1, 7'd33);
    mem[2] = enc_r(3'd0, 3'd0, 3'd1, 4'd9);
    mem[3] = enc_i(3'd2, 3'd0, 3'd1, 7'd40);
    run_prog(c);
    chk("R10", "register kept", 32'(mem[40]), 32'd5);
    chk("R10", "memory kept", 32'(mem[33]), 32'hE000);
    chk("R10", "cycles", 32'(c), 32'd13);
  endtask

  task automatic t_halt();
    int c, bad;
    clear_mem();
    run_prog(c);
    chk("R9", "halt latency", 32'(c), 32'd2);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || mem_rd || mem_wr) bad++;
    end
    chk("R9", "quiet while halted", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_alu();
    t_disp();
    t_reset();
    t_ldst();
    t_branch();
    t_jump();
    t_undef();
    t_halt();
    chk("R12", "read/write overlap cycles", 32'(overlap), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule